// File: doc/BRIEF.md
# SCSI DMA transfer length controller

This block sequences one DMA transfer for a SCSI host adapter. On a transfer-information strobe in DMA mode it decodes the 16-bit programmed count, which the register file supplies as a low byte and a high byte. It then works out the chunk to move, bounding it by the size of the device's signed residual byte count, or by a fixed command-buffer size when a command phase is pending. The chunk is loaded into a remaining-DMA counter. The block does not move data itself. It issues memory requests that carry a length and a direction. Memory movement and the SCSI device itself lie outside the block.

Each memory request moves whichever is smaller: the remaining DMA count or the buffer length that the device layer last offered. After each accepted request the block updates the counter, the residual and the buffer length. It then decides whether to raise completion straight away or to defer it until the device layer reports again. Completion and command-done events update the status and interrupt register images, pulse a clear of the count and sequence registers, and raise the interrupt line.

Top module: `scsi_dma_len_ctrl`

## Requirements
- R1: The programmed count is `{cnt_hi_i, cnt_lo_i}`, and a count of 0 stands for 65536. Outside command phase the loaded chunk (seen on `dma_left_o`) is the smaller of that count and the magnitude of `resid_i`.
- R2: A start with `cmd_phase_i`=1 loads the smaller of the count and 32. It then issues a single request of the whole chunk with `mreq_to_dev_o`=1, regardless of buffer data. On acceptance the remaining count and the residual go to 0 and no completion is raised.
- R3: A start (`start_i` with `dma_mode_i`=1) captures `resid_i`, loads the remaining count and clears status bit 4 (0x10). A start with `dma_mode_i`=0 has no effect.
- R4: A request of length min(remaining count, available buffer length) is issued only when both are nonzero. While no device data is available, no request is made.
- R5: A negative residual gives `mreq_to_dev_o`=1, and each accepted step adds its length to the residual. Otherwise `mreq_to_dev_o`=0 and the step length is subtracted.
- R6: A step that leaves device buffer bytes unconsumed raises completion at once.
- R7: A step that empties the buffer raises completion only if it moves data to memory (residual not negative), the remaining count is now 0 and the residual is still above 0. A step toward the device that empties the buffer never raises completion.
- R8: A device data-ready pulse that arrives when the remaining count is 0 raises completion if the last loaded count is nonzero and the residual is at or below 0.
- R9: On completion, status bits 7 and 4 (0x90) are set, `intr_o` becomes 0x10, `clr_cnt_o` pulses high for one cycle (clearing count registers 0 and 1 and registers 6 and 7), and `irq_o` rises.
- R10: `dev_done_i` zeroes the residual, the remaining count and the buffer length and drops any request. It sets status to 0x03 and runs completion, so status reads 0x93.
- R11: A request stays asserted with a stable length and direction until `mreq_ready_i` accepts it.
- R12: `intr_ack_i` lowers `irq_o` and clears status bit 7, unless a completion occurs in the same cycle.
- R13: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Transfer-information strobe |
| dma_mode_i | input | 1 | Strobe is a DMA command |
| cmd_phase_i | input | 1 | Command bytes pending from memory |
| cnt_lo_i | input | 8 | Programmed count, low byte |
| cnt_hi_i | input | 8 | Programmed count, high byte |
| resid_i | input | RES_W | Signed device residual, captured at start |
| dev_rdy_i | input | 1 | Device buffer data-ready pulse |
| dev_len_i | input | BUF_W | Bytes offered by the device buffer |
| dev_done_i | input | 1 | Device reports command done |
| intr_ack_i | input | 1 | Interrupt register read |
| mreq_ready_i | input | 1 | Memory side accepts request |
| mreq_valid_o | output | 1 | Memory request pending |
| mreq_len_o | output | CNT_W+1 | Request length in bytes |
| mreq_to_dev_o | output | 1 | 1: memory read toward device; 0: write to memory |
| dma_left_o | output | CNT_W+1 | Remaining DMA count |
| resid_o | output | RES_W | Current signed residual |
| status_o | output | 8 | Status register image |
| intr_o | output | 8 | Interrupt register image |
| irq_o | output | 1 | Interrupt line |
| clr_cnt_o | output | 1 | One-cycle clear of count and sequence registers |

## Verification
Most internal faults reach the ports within two cycles. A wrong chunk or step length appears on `mreq_len_o` one cycle after the device data-ready pulse, and a wrong residual update or direction shows on `resid_o` or `mreq_to_dev_o` right after the handshake. A faulty completion decision is the subtlest case, because it alters only `irq_o`, `status_o` and `clr_cnt_o`. The bench therefore checks those ports after every accepted step and after late data-ready pulses. A stuck buffer-length register shows up as a request that never appears or one that does not stop, so the waits have bounded windows.

// File: rtl/sdl_pkg.sv
package sdl_pkg;
  localparam logic [7:0] ST_IRQ   = 8'h80;
  localparam logic [7:0] ST_CNTZ  = 8'h10;
  localparam logic [7:0] ST_PHASE = 8'h03;
  localparam logic [7:0] IV_SVC   = 8'h10;

  typedef enum logic [2:0] {
    EV_IDLE,
    EV_DONE,
    EV_START,
    EV_ACCEPT,
    EV_DATA
  } sdl_ev_e;
endpackage

// File: rtl/sdl_chunk_calc.sv
module sdl_chunk_calc #(
  parameter int CNT_W   = 16,
  parameter int RES_W   = 24,
  parameter int CMD_MAX = 32,
  localparam int LEN_W  = CNT_W + 1
) (
  input  logic [CNT_W-1:0]        prog_i,
  input  logic                    cmd_i,
  input  logic signed [RES_W-1:0] res_i,
  output logic [LEN_W-1:0]        total_o,
  output logic [LEN_W-1:0]        chunk_o
);
  localparam int WW = (RES_W > LEN_W) ? RES_W : LEN_W;

  logic [RES_W-1:0] mag;
  logic [WW-1:0]    mag_w, tot_w, lim_w;

  always_comb begin
    total_o = (prog_i == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, prog_i};
    mag     = res_i[RES_W-1] ? RES_W'(-res_i) : RES_W'(res_i);
    mag_w   = WW'(mag);
    tot_w   = WW'(total_o);
    lim_w   = cmd_i ? WW'(CMD_MAX) : mag_w;
    chunk_o = (lim_w < tot_w) ? LEN_W'(lim_w) : total_o;
  end
endmodule

// File: rtl/sdl_step_calc.sv
module sdl_step_calc #(
  parameter int CNT_W  = 16,
  parameter int RES_W  = 24,
  parameter int BUF_W  = 16,
  localparam int LEN_W = CNT_W + 1
) (
  input  logic [LEN_W-1:0]        left_i,
  input  logic [BUF_W-1:0]        buf_i,
  input  logic signed [RES_W-1:0] res_i,
  input  logic                    cmd_i,
  output logic [LEN_W-1:0]        step_o,
  output logic                    to_dev_o,
  output logic [LEN_W-1:0]        left_n_o,
  output logic [BUF_W-1:0]        buf_n_o,
  output logic signed [RES_W-1:0] res_n_o,
  output logic                    fire_o
);
  logic [LEN_W-1:0] buf_w;

  always_comb begin
    buf_w = LEN_W'(buf_i);
    if (cmd_i) begin
      step_o   = left_i;
      to_dev_o = 1'b1;
      left_n_o = '0;
      buf_n_o  = buf_i;
      res_n_o  = '0;
      fire_o   = 1'b0;
    end else begin
      step_o   = (left_i < buf_w) ? left_i : buf_w;
      to_dev_o = res_i[RES_W-1];
      left_n_o = left_i - step_o;
      buf_n_o  = buf_i - BUF_W'(step_o);
      res_n_o  = to_dev_o ? (res_i + $signed(RES_W'(step_o)))
                          : (res_i - $signed(RES_W'(step_o)));
      fire_o   = (buf_n_o != '0) ||
                 (!to_dev_o && (left_n_o == '0) && (res_n_o > 0));
    end
  end
endmodule

// File: rtl/sdl_cpl_regs.sv
module sdl_cpl_regs
  import sdl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start_ev_i,
  input  logic       done_ev_i,
  input  logic       cpl_ev_i,
  input  logic       ack_i,
  output logic [7:0] status_o,
  output logic [7:0] intr_o,
  output logic       irq_o,
  output logic       clr_o
);
  logic [7:0] stat_nxt;

  always_comb begin
    stat_nxt = status_o;
    if (done_ev_i)       stat_nxt = ST_PHASE | ST_IRQ | ST_CNTZ;
    else if (cpl_ev_i)   stat_nxt = status_o | ST_IRQ | ST_CNTZ;
    else begin
      if (start_ev_i) stat_nxt = stat_nxt & ~ST_CNTZ;
      if (ack_i)      stat_nxt = stat_nxt & ~ST_IRQ;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_o <= '0;
      intr_o   <= '0;
      irq_o    <= 1'b0;
      clr_o    <= 1'b0;
    end else begin
      status_o <= stat_nxt;
      clr_o    <= done_ev_i | cpl_ev_i;
      if (done_ev_i || cpl_ev_i) begin
        intr_o <= IV_SVC;
        irq_o  <= 1'b1;
      end else if (ack_i) begin
        irq_o  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/scsi_dma_len_ctrl.sv
module scsi_dma_len_ctrl
  import sdl_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int RES_W   = 24,
  parameter int BUF_W   = 16,
  parameter int CMD_MAX = 32,
  localparam int LEN_W  = CNT_W + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start_i,
  input  logic                    dma_mode_i,
  input  logic                    cmd_phase_i,
  input  logic [7:0]              cnt_lo_i,
  input  logic [7:0]              cnt_hi_i,
  input  logic signed [RES_W-1:0] resid_i,
  input  logic                    dev_rdy_i,
  input  logic [BUF_W-1:0]        dev_len_i,
  input  logic                    dev_done_i,
  input  logic                    intr_ack_i,
  input  logic                    mreq_ready_i,
  output logic                    mreq_valid_o,
  output logic [LEN_W-1:0]        mreq_len_o,
  output logic                    mreq_to_dev_o,
  output logic [LEN_W-1:0]        dma_left_o,
  output logic signed [RES_W-1:0] resid_o,
  output logic [7:0]              status_o,
  output logic [7:0]              intr_o,
  output logic                    irq_o,
  output logic                    clr_cnt_o
);
  logic [LEN_W-1:0]        total_r;
  logic [BUF_W-1:0]        buf_r;
  logic                    cmd_r;

  logic [LEN_W-1:0]        total_w, chunk_w;
  logic [LEN_W-1:0]        step_w, left_n_w;
  logic [BUF_W-1:0]        buf_n_w;
  logic signed [RES_W-1:0] res_n_w;
  logic                    to_dev_w, fire_w;

  sdl_ev_e ev;
  logic    want_req, late_cpl, cpl_ev;

  sdl_chunk_calc #(.CNT_W(CNT_W), .RES_W(RES_W), .CMD_MAX(CMD_MAX)) chunk_i (
    .prog_i  (CNT_W'({cnt_hi_i, cnt_lo_i})),
    .cmd_i   (cmd_phase_i),
    .res_i   (resid_i),
    .total_o (total_w),
    .chunk_o (chunk_w)
  );

  sdl_step_calc #(.CNT_W(CNT_W), .RES_W(RES_W), .BUF_W(BUF_W)) step_i (
    .left_i   (dma_left_o),
    .buf_i    (buf_r),
    .res_i    (resid_o),
    .cmd_i    (cmd_r),
    .step_o   (step_w),
    .to_dev_o (to_dev_w),
    .left_n_o (left_n_w),
    .buf_n_o  (buf_n_w),
    .res_n_o  (res_n_w),
    .fire_o   (fire_w)
  );

  always_comb begin
    if (dev_done_i)                           ev = EV_DONE;
    else if (start_i && dma_mode_i && !mreq_valid_o) ev = EV_START;
    else if (mreq_valid_o && mreq_ready_i)    ev = EV_ACCEPT;
    else if (dev_rdy_i && !mreq_valid_o)      ev = EV_DATA;
    else                                      ev = EV_IDLE;
  end

  assign want_req = (dma_left_o != '0) && (cmd_r || (buf_r != '0));
  assign late_cpl = (ev == EV_DATA) && (dma_left_o == '0) &&
                    (total_r != '0) && (resid_o <= 0);
  assign cpl_ev   = ((ev == EV_ACCEPT) && fire_w) || late_cpl;

  always_ff @(posedge clk) begin
    if (rst) begin
      total_r       <= '0;
      buf_r         <= '0;
      cmd_r         <= 1'b0;
      dma_left_o    <= '0;
      resid_o       <= '0;
      mreq_valid_o  <= 1'b0;
      mreq_len_o    <= '0;
      mreq_to_dev_o <= 1'b0;
    end else begin
      unique case (ev)
        EV_DONE: begin
          resid_o      <= '0;
          dma_left_o   <= '0;
          buf_r        <= '0;
          cmd_r        <= 1'b0;
          mreq_valid_o <= 1'b0;
        end
        EV_START: begin
          dma_left_o <= chunk_w;
          total_r    <= total_w;
          resid_o    <= resid_i;
          cmd_r      <= cmd_phase_i;
        end
        EV_ACCEPT: begin
          mreq_valid_o <= 1'b0;
          dma_left_o   <= left_n_w;
          buf_r        <= buf_n_w;
          resid_o      <= res_n_w;
          cmd_r        <= 1'b0;
        end
        default: begin
          if (ev == EV_DATA) buf_r <= dev_len_i;
          if (want_req) begin
            mreq_valid_o  <= 1'b1;
            mreq_len_o    <= step_w;
            mreq_to_dev_o <= to_dev_w;
          end
        end
      endcase
    end
  end

  sdl_cpl_regs cpl_i (
    .clk        (clk),
    .rst        (rst),
    .start_ev_i (ev == EV_START),
    .done_ev_i  (ev == EV_DONE),
    .cpl_ev_i   (cpl_ev),
    .ack_i      (intr_ack_i),
    .status_o   (status_o),
    .intr_o     (intr_o),
    .irq_o      (irq_o),
    .clr_o      (clr_cnt_o)
  );
endmodule

// File: rtl/sdl_checker.sv
module sdl_checker #(
  parameter int CNT_W  = 16,
  parameter int RES_W  = 24,
  localparam int LEN_W = CNT_W + 1
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    start_i,
  input logic                    dma_mode_i,
  input logic                    dev_done_i,
  input logic                    intr_ack_i,
  input logic                    mreq_ready_i,
  input logic                    mreq_valid_o,
  input logic [LEN_W-1:0]        mreq_len_o,
  input logic                    mreq_to_dev_o,
  input logic [LEN_W-1:0]        dma_left_o,
  input logic signed [RES_W-1:0] resid_o,
  input logic [7:0]              status_o,
  input logic [7:0]              intr_o,
  input logic                    irq_o,
  input logic                    clr_cnt_o
);
  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (mreq_valid_o && !mreq_ready_i && !dev_done_i) |=>
      (mreq_valid_o && $stable(mreq_len_o) && $stable(mreq_to_dev_o)));

  assert_req_len_R4: assert property (@(posedge clk) disable iff (rst)
    mreq_valid_o |-> (mreq_len_o != '0));

  assert_left_only_loads_R3: assert property (@(posedge clk) disable iff (rst)
    !(start_i && dma_mode_i) |=> (dma_left_o <= $past(dma_left_o)));

  assert_start_clears_R3: assert property (@(posedge clk) disable iff (rst)
    (start_i && dma_mode_i && !mreq_valid_o && !dev_done_i) |=> !status_o[4]);

  assert_done_R10: assert property (@(posedge clk) disable iff (rst)
    dev_done_i |=> (dma_left_o == '0 && resid_o == '0 && status_o == 8'h93 &&
                    irq_o && !mreq_valid_o));

  assert_cpl_R9: assert property (@(posedge clk) disable iff (rst)
    clr_cnt_o |-> (irq_o && intr_o == 8'h10 && status_o[7] && status_o[4]));

  assert_ack_R12: assert property (@(posedge clk) disable iff (rst)
    (intr_ack_i && !dev_done_i) |=> (!irq_o || clr_cnt_o));
endmodule

bind scsi_dma_len_ctrl sdl_checker #(.CNT_W(CNT_W), .RES_W(RES_W)) chk_i (
  .clk           (clk),
  .rst           (rst),
  .start_i       (start_i),
  .dma_mode_i    (dma_mode_i),
  .dev_done_i    (dev_done_i),
  .intr_ack_i    (intr_ack_i),
  .mreq_ready_i  (mreq_ready_i),
  .mreq_valid_o  (mreq_valid_o),
  .mreq_len_o    (mreq_len_o),
  .mreq_to_dev_o (mreq_to_dev_o),
  .dma_left_o    (dma_left_o),
  .resid_o       (resid_o),
  .status_o      (status_o),
  .intr_o        (intr_o),
  .irq_o         (irq_o),
  .clr_cnt_o     (clr_cnt_o)
);

// File: tb/scsi_dma_len_ctrl_tb_top.sv
module scsi_dma_len_ctrl_tb_top;
  localparam int CNT_W = 16;
  localparam int RES_W = 24;
  localparam int BUF_W = 16;
  localparam int LEN_W = CNT_W + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 0, dma_mode_i = 0, cmd_phase_i = 0;
  logic [7:0] cnt_lo_i = 0, cnt_hi_i = 0;
  logic signed [RES_W-1:0] resid_i = 0;
  logic dev_rdy_i = 0, dev_done_i = 0, intr_ack_i = 0, mreq_ready_i = 0;
  logic [BUF_W-1:0] dev_len_i = 0;
  logic mreq_valid_o, mreq_to_dev_o, irq_o, clr_cnt_o;
  logic [LEN_W-1:0] mreq_len_o, dma_left_o;
  logic signed [RES_W-1:0] resid_o;
  logic [7:0] status_o, intr_o;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  scsi_dma_len_ctrl dut_i (.*);

  typedef struct packed {
    logic [15:0]        cnt;
    logic signed [23:0] res;
    logic [15:0]        dev;
    logic [16:0]        chunk;
    logic [16:0]        step;
    logic               dir;
    logic               cpl;
    logic [16:0]        left;
    logic signed [23:0] res_after;
  } vec_t;

  localparam vec_t TABLE [9] = '{
    '{16'h0100,  24'sd100,   16'd40,   17'd100,   17'd40,   1'b0, 1'b0, 17'd60,    24'sd60},
    '{16'h0040,  24'sd200,   16'd64,   17'd64,    17'd64,   1'b0, 1'b1, 17'd0,     24'sd136},
    '{16'h0032,  24'sd50,    16'd50,   17'd50,    17'd50,   1'b0, 1'b0, 17'd0,     24'sd0},
    '{16'h001E,  24'sd100,   16'd80,   17'd30,    17'd30,   1'b0, 1'b1, 17'd0,     24'sd70},
    '{16'h0000,  24'sd70000, 16'd1000, 17'h10000, 17'd1000, 1'b0, 1'b0, 17'd64536, 24'sd69000},
    '{16'h0014, -24'sd12,    16'd12,   17'd12,    17'd12,   1'b1, 1'b0, 17'd0,     24'sd0},
    '{16'h0064, -24'sd300,   16'd40,   17'd100,   17'd40,   1'b1, 1'b0, 17'd60,   -24'sd260},
    '{16'h000A, -24'sd300,   16'd40,   17'd10,    17'd10,   1'b1, 1'b1, 17'd0,    -24'sd290},
    '{16'h1234,  24'sd5000,  16'd4660, 17'd4660,  17'd4660, 1'b0, 1'b1, 17'd0,     24'sd340}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_state(input bit do_chk);
    dev_done_i = 1'b1;
    @(negedge clk);
    dev_done_i = 1'b0;
    if (do_chk) begin
      chk("R10 status", 32'(status_o), 32'h93);
      chk("R10 left", 32'(dma_left_o), 32'h0);
      chk("R10 resid", {8'h0, resid_o}, 32'h0);
      chk("R10 irq", 32'(irq_o), 32'h1);
      chk("R9 clr pulse", 32'(clr_cnt_o), 32'h1);
    end
    intr_ack_i = 1'b1;
    @(negedge clk);
    intr_ack_i = 1'b0;
    if (do_chk) begin
      chk("R12 irq low", 32'(irq_o), 32'h0);
      chk("R12 status", 32'(status_o), 32'h13);
    end
  endtask

  task automatic do_start(input logic [15:0] cnt, input logic signed [23:0] res,
                          input bit cmd, input bit dma);
    start_i = 1'b1; dma_mode_i = dma; cmd_phase_i = cmd;
    {cnt_hi_i, cnt_lo_i} = cnt; resid_i = res;
    @(negedge clk);
    start_i = 1'b0; dma_mode_i = 1'b0; cmd_phase_i = 1'b0;
  endtask

  task automatic do_rdy(input logic [15:0] len);
    dev_rdy_i = 1'b1; dev_len_i = len;
    @(negedge clk);
    dev_rdy_i = 1'b0;
  endtask

  task automatic wait_valid(output bit got);
    got = 1'b0;
    for (int k = 0; k < 8; k++) begin
      if (mreq_valid_o) begin
        got = 1'b1;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic accept();
    mreq_ready_i = 1'b1;
    @(negedge clk);
    mreq_ready_i = 1'b0;
  endtask

  initial begin
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    bit got;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R13 reset state
    chk("R13 valid", 32'(mreq_valid_o), 0);
    chk("R13 status", 32'(status_o), 0);
    chk("R13 intr", 32'(intr_o), 0);
    chk("R13 irq", 32'(irq_o), 0);
    chk("R13 left", 32'(dma_left_o), 0);

    for (int i = 0; i < 9; i++) begin
      clear_state(i == 0);
      do_start(TABLE[i].cnt, TABLE[i].res, 1'b0, 1'b1);
      chk("R1 chunk", 32'(dma_left_o), 32'(TABLE[i].chunk));
      chk("R3 status bit4 clear", 32'(status_o), 32'h03);
      do_rdy(TABLE[i].dev);
      wait_valid(got);
      chk("R4 request seen", 32'(got), 1);
      chk("R4 step length", 32'(mreq_len_o), 32'(TABLE[i].step));
      chk("R5 direction", 32'(mreq_to_dev_o), 32'(TABLE[i].dir));
      accept();
      chk("R5 resid after", {8'h0, resid_o}, {8'h0, TABLE[i].res_after});
      chk("R4 left after", 32'(dma_left_o), 32'(TABLE[i].left));
      chk("R6 R7 completion", 32'(irq_o), 32'(TABLE[i].cpl));
      chk("R9 status", 32'(status_o), TABLE[i].cpl ? 32'h93 : 32'h03);
      if (TABLE[i].cpl) chk("R9 intr", 32'(intr_o), 32'h10);
    end

    // R3 start without DMA mode ignored
    clear_state(1'b0);
    do_start(16'd100, 24'sd50, 1'b0, 1'b0);
    @(negedge clk);
    chk("R3 ignored left", 32'(dma_left_o), 0);
    chk("R3 ignored status", 32'(status_o), 32'h13);

    // R4 wait without data, R11 hold
    clear_state(1'b0);
    do_start(16'd100, 24'sd50, 1'b0, 1'b1);
    repeat (5) @(negedge clk);
    chk("R4 no request", 32'(mreq_valid_o), 0);
    chk("R4 left held", 32'(dma_left_o), 50);
    do_rdy(16'd20);
    wait_valid(got);
    repeat (4) @(negedge clk);
    chk("R11 still valid", 32'(mreq_valid_o), 1);
    chk("R11 len stable", 32'(mreq_len_o), 20);
    accept();
    chk("R4 left after", 32'(dma_left_o), 30);
    chk("R7 no cpl", 32'(irq_o), 0);

    // R2 command phase
    clear_state(1'b0);
    do_start(16'd100, 24'sd500, 1'b1, 1'b1);
    chk("R2 chunk", 32'(dma_left_o), 32);
    wait_valid(got);
    chk("R2 request", 32'(got), 1);
    chk("R2 len", 32'(mreq_len_o), 32);
    chk("R2 dir", 32'(mreq_to_dev_o), 1);
    accept();
    chk("R2 left", 32'(dma_left_o), 0);
    chk("R2 resid", {8'h0, resid_o}, 0);
    chk("R2 no cpl", 32'(irq_o), 0);

    // R8 late completion, residual at zero
    clear_state(1'b0);
    do_start(16'd20, -24'sd12, 1'b0, 1'b1);
    do_rdy(16'd12);
    wait_valid(got);
    accept();
    chk("R7 write no cpl", 32'(irq_o), 0);
    do_rdy(16'd5);
    chk("R8 late cpl", 32'(irq_o), 1);
    chk("R8 status", 32'(status_o), 32'h93);

    // R8 negative: residual positive, no late completion
    clear_state(1'b0);
    do_start(16'd50, 24'sd60, 1'b0, 1'b1);
    do_rdy(16'd50);
    wait_valid(got);
    accept();
    chk("R7 read cpl", 32'(irq_o), 1);
    intr_ack_i = 1'b1;
    @(negedge clk);
    intr_ack_i = 1'b0;
    chk("R12 ack", 32'(irq_o), 0);
    do_rdy(16'd5);
    @(negedge clk);
    chk("R8 no late cpl", 32'(irq_o), 0);
    chk("R8 no request", 32'(mreq_valid_o), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule